// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block sits between a 64-bit internal data path and a quad-pumped, active-low host data bus. On the transmit side it takes a 64-byte cache line and sends it as eight consecutive 64-bit data phases, one per phase-clock cycle. Each phase is split into four 16-bit segments. Every segment is checked on its own. If driving it would pull more than half of its lines electrically low, the segment is sent inverted and its active-low inversion flag is asserted.

On the receive side each 64-bit phase arrives with its four flags. A segment whose flag is asserted is inverted back, and then the word is handed to the internal side. The transmit and receive paths are independent, so a transmit output looped onto the receive input returns the original data. The clock is the phase clock, which runs at four times the bus clock. The asynchronous active-low reset is synchronised inside the block before use.

Top module: `dbi_codec`

## Requirements
- R1: After reset and whenever no phase is being sent, `bus_tx_lines` is all ones, `bus_tx_inv_n` is all ones (deasserted), and `bus_tx_valid` and `line_done` are low. After reset `rx_word_valid` is low and `rx_word` is zero.
- R2: Segment s of a phase is bits [16s+15:16s], and its inversion flag is bit s of `bus_tx_inv_n` and `bus_rx_inv_n`.
- R3: Bus lines are active low. A segment that is not inverted drives the bitwise complement of its logical value, and its flag bit is 1.
- R4: A segment whose logical value has more than eight ones (more than eight lines would go low) is sent unmodified as its logical value on the lines, and its flag bit is 0.
- R5: A segment with exactly eight logical ones is not inverted.
- R6: No transmitted segment ever has more than eight lines at 0.
- R7: After `line_start` is sampled with `line_data` at clock edge E0, phase k (k = 0..7) carries `line_data[64k+63:64k]` and is on the bus with `bus_tx_valid` high after edge E(k+1). The phases follow in ascending order with no gaps.
- R8: `line_done` is high for exactly one cycle, together with phase 7.
- R9: `line_start` is accepted when the block is idle or during the cycle in which phase 7 is being prepared, which gives back-to-back lines with no gap. At any other busy cycle it is ignored and the line in flight is unaffected.
- R10: When `bus_rx_valid` is sampled high, one cycle later `rx_word_valid` is high. `rx_word` then holds the received lines with every segment whose flag is 1 complemented, and every segment whose flag is 0 passed through.
- R11: Feeding the transmit outputs into the receive inputs returns every phase's original 64 bits.
- R12: While `bus_rx_valid` is low, `rx_word` keeps its value and `rx_word_valid` is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (four data phases per bus clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | Begin sending the line on `line_data` |
| line_data | input | 512 | Cache line; bytes 0..7 form phase 0 |
| bus_tx_lines | output | 64 | Electrical transmit data lines |
| bus_tx_inv_n | output | 4 | Active-low per-segment inversion flags, transmit |
| bus_tx_valid | output | 1 | A data phase is on the transmit lines |
| line_done | output | 1 | Marks the final phase of a line |
| bus_rx_lines | input | 64 | Electrical receive data lines |
| bus_rx_inv_n | input | 4 | Active-low per-segment inversion flags, receive |
| bus_rx_valid | input | 1 | A data phase is present on the receive inputs |
| rx_word | output | 64 | Restored logical receive word |
| rx_word_valid | output | 1 | `rx_word` was updated this cycle |

## Verification
The hardest situation to reach from the ports is a `line_start` that lands while a line is being serialised. The request is ignored mid-line but accepted on the final phase, and the two cases differ by a single cycle. The driver task times its pulses by counting phase-clock edges from the accepted start. It injects a competing start at phase 3 and chains lines exactly on phase 7, and the scoreboard confirms that the bus shows only the intended phases in order. Segments with exactly eight, nine, seven, zero and sixteen ones are placed into every segment position by rotating a pattern set, so that the threshold is exercised in each lane.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int DBI_SEG_W  = 16;
  localparam int DBI_NSEG   = 4;
  localparam int DBI_PHASES = 8;

  // Restore a logical word from electrical lines and active-low flags.
  function automatic logic [DBI_SEG_W*DBI_NSEG-1:0] dbi_restore(
      input logic [DBI_SEG_W*DBI_NSEG-1:0] lines,
      input logic [DBI_NSEG-1:0]           inv_n);
    logic [DBI_SEG_W*DBI_NSEG-1:0] w;
    for (int s = 0; s < DBI_NSEG; s++) begin
      w[s*DBI_SEG_W +: DBI_SEG_W] = inv_n[s] ? ~lines[s*DBI_SEG_W +: DBI_SEG_W]
                                             :  lines[s*DBI_SEG_W +: DBI_SEG_W];
    end
    return w;
  endfunction
endpackage

// File: rtl/dbi_rst_sync.sv
module dbi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/dbi_seg_enc.sv
module dbi_seg_enc #(
  parameter int W = 16
) (
  input  logic [W-1:0] logic_i,
  output logic [W-1:0] lines_o,
  output logic         inv_n_o
);
  localparam int CW   = $clog2(W + 1);
  localparam int HALF = W / 2;

  logic [CW-1:0] ones;
  logic          flip;

  // Logical ones map to electrically low lines.
  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) begin
      ones = ones + CW'(logic_i[i]);
    end
    flip    = (ones > CW'(HALF));
    lines_o = flip ? logic_i : ~logic_i;
    inv_n_o = ~flip;
  end
endmodule

// File: rtl/dbi_seg_dec.sv
module dbi_seg_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] lines_i,
  input  logic         inv_n_i,
  output logic [W-1:0] logic_o
);
  always_comb begin
    logic_o = inv_n_i ? ~lines_i : lines_i;
  end
endmodule

// File: rtl/dbi_line_ser.sv
module dbi_line_ser #(
  parameter int WORD_W = 64,
  parameter int PHASES = 8
) (
  input  logic                       clk,
  input  logic                       rst_sn,
  input  logic                       start_i,
  input  logic [WORD_W*PHASES-1:0]   line_i,
  output logic [WORD_W-1:0]          word_o,
  output logic                       valid_o,
  output logic                       last_o
);
  localparam int LINE_W = WORD_W * PHASES;
  localparam int IW     = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(PHASES - 1);

  logic [LINE_W-1:0] line_q;
  logic [IW-1:0]     idx_q, idx_d;
  logic              busy_q, busy_d;
  logic              at_last, accept;

  assign at_last = busy_q && (idx_q == LAST_IDX);
  assign accept  = start_i && (!busy_q || at_last);

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (at_last) begin
      busy_d = 1'b0;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d  = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  // Line storage: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (accept) line_q <= line_i;
  end

  assign word_o  = line_q[idx_q*WORD_W +: WORD_W];
  assign valid_o = busy_q;
  assign last_o  = at_last;

  // R7: phases advance by one each cycle while a line is in flight
  assert_phase_step_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && !at_last) |=> (busy_q && idx_q == $past(idx_q) + IW'(1)));

  // R9: a line in flight is not restarted before its last phase
  assert_no_midline_restart_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy_q && !at_last && start_i) |=> (idx_q != '0));
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec #(
  parameter int SEG_W  = dbi_pkg::DBI_SEG_W,
  parameter int NSEG   = dbi_pkg::DBI_NSEG,
  parameter int PHASES = dbi_pkg::DBI_PHASES
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              line_start,
  input  logic [SEG_W*NSEG*PHASES-1:0]      line_data,
  output logic [SEG_W*NSEG-1:0]             bus_tx_lines,
  output logic [NSEG-1:0]                   bus_tx_inv_n,
  output logic                              bus_tx_valid,
  output logic                              line_done,
  input  logic [SEG_W*NSEG-1:0]             bus_rx_lines,
  input  logic [NSEG-1:0]                   bus_rx_inv_n,
  input  logic                              bus_rx_valid,
  output logic [SEG_W*NSEG-1:0]             rx_word,
  output logic                              rx_word_valid
);
  localparam int WORD_W = SEG_W * NSEG;
  localparam int HALF   = SEG_W / 2;

  logic rst_sn;

  dbi_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  logic [WORD_W-1:0] ser_word;
  logic              ser_valid, ser_last;

  dbi_line_ser #(.WORD_W(WORD_W), .PHASES(PHASES)) u_ser (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .start_i (line_start),
    .line_i  (line_data),
    .word_o  (ser_word),
    .valid_o (ser_valid),
    .last_o  (ser_last)
  );

  logic [WORD_W-1:0] enc_lines;
  logic [NSEG-1:0]   enc_inv_n;
  logic [WORD_W-1:0] dec_word;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    dbi_seg_enc #(.W(SEG_W)) u_enc (
      .logic_i (ser_word [s*SEG_W +: SEG_W]),
      .lines_o (enc_lines[s*SEG_W +: SEG_W]),
      .inv_n_o (enc_inv_n[s])
    );
    dbi_seg_dec #(.W(SEG_W)) u_dec (
      .lines_i (bus_rx_lines[s*SEG_W +: SEG_W]),
      .inv_n_i (bus_rx_inv_n[s]),
      .logic_o (dec_word[s*SEG_W +: SEG_W])
    );
  end

  // Transmit register stage
  logic [WORD_W-1:0] tx_lines_q, tx_lines_d;
  logic [NSEG-1:0]   tx_inv_q, tx_inv_d;
  logic              tx_valid_q, tx_valid_d;
  logic              done_q, done_d;

  always_comb begin
    if (ser_valid) begin
      tx_lines_d = enc_lines;
      tx_inv_d   = enc_inv_n;
      tx_valid_d = 1'b1;
      done_d     = ser_last;
    end else begin
      tx_lines_d = '1;
      tx_inv_d   = '1;
      tx_valid_d = 1'b0;
      done_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      tx_lines_q <= '1;
      tx_inv_q   <= '1;
      tx_valid_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      tx_lines_q <= tx_lines_d;
      tx_inv_q   <= tx_inv_d;
      tx_valid_q <= tx_valid_d;
      done_q     <= done_d;
    end
  end

  // Receive register stage
  logic [WORD_W-1:0] rx_word_q, rx_word_d;
  logic              rx_valid_q;

  always_comb begin
    rx_word_d = bus_rx_valid ? dec_word : rx_word_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rx_word_q  <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_word_q  <= rx_word_d;
      rx_valid_q <= bus_rx_valid;
    end
  end

  assign bus_tx_lines  = tx_lines_q;
  assign bus_tx_inv_n  = tx_inv_q;
  assign bus_tx_valid  = tx_valid_q;
  assign line_done     = done_q;
  assign rx_word       = rx_word_q;
  assign rx_word_valid = rx_valid_q;

  // R1: idle bus holds all lines and flags high
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    !tx_valid_q |-> (tx_lines_q == '1 && tx_inv_q == '1 && !done_q));

  // R6: no segment on the bus exceeds half its lines low
  for (genvar s = 0; s < NSEG; s++) begin : g_chk
    assert_low_limit_R6: assert property (@(posedge clk) disable iff (!rst_sn)
      tx_valid_q |-> ($countones(~tx_lines_q[s*SEG_W +: SEG_W]) <= HALF));
  end

  // R11: the bus phase restores to the word the serializer offered a cycle earlier
  assert_roundtrip_R11: assert property (@(posedge clk) disable iff (!rst_sn)
    tx_valid_q |-> (dbi_pkg::dbi_restore(tx_lines_q, tx_inv_q) == $past(ser_word)));

  // R8: the done marker only accompanies a valid phase
  assert_done_with_phase_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |-> tx_valid_q);

  // R12: received word does not move without a received phase
  assert_rx_hold_R12: assert property (@(posedge clk) disable iff (!rst_sn)
    !rx_valid_q |-> $stable(rx_word_q));
endmodule

// File: tb/dbi_codec_bench.sv
module dbi_codec_bench;
  localparam int SEG_W = 16;
  localparam int NSEG  = 4;
  localparam int PH    = 8;
  localparam int WW    = SEG_W * NSEG;
  localparam int LW    = WW * PH;

  typedef struct packed {
    logic [WW-1:0]   lines;
    logic [NSEG-1:0] inv_n;
    logic            done;
  } tx_item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            line_start = 1'b0;
  logic [LW-1:0]   line_data = '0;
  logic [WW-1:0]   bus_tx_lines;
  logic [NSEG-1:0] bus_tx_inv_n;
  logic            bus_tx_valid, line_done;
  logic [WW-1:0]   rx_word;
  logic            rx_word_valid;

  logic            loop_en = 1'b1;
  logic [WW-1:0]   drv_lines = '0;
  logic [NSEG-1:0] drv_inv_n = '1;
  logic            drv_valid = 1'b0;
  logic [WW-1:0]   rx_lines_w;
  logic [NSEG-1:0] rx_inv_w;
  logic            rx_valid_w;

  assign rx_lines_w = loop_en ? bus_tx_lines : drv_lines;
  assign rx_inv_w   = loop_en ? bus_tx_inv_n : drv_inv_n;
  assign rx_valid_w = loop_en ? bus_tx_valid : drv_valid;

  always #2 clk = ~clk;

  dbi_codec u_dbi_codec (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_data(line_data),
    .bus_tx_lines(bus_tx_lines), .bus_tx_inv_n(bus_tx_inv_n),
    .bus_tx_valid(bus_tx_valid), .line_done(line_done),
    .bus_rx_lines(rx_lines_w), .bus_rx_inv_n(rx_inv_w), .bus_rx_valid(rx_valid_w),
    .rx_word(rx_word), .rx_word_valid(rx_word_valid)
  );

  int n_tests = 0;
  int n_fail  = 0;
  tx_item_t      exp_tx[$];
  logic [WW-1:0] exp_rx[$];
  bit            mon_on = 1'b0;

  task automatic check(input bit ok, input string what,
                       input logic [WW+4:0] act, input logic [WW+4:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Reference encoding from R3/R4/R5: returns {inv_n, lines}
  function automatic logic [WW+NSEG-1:0] ref_enc(input logic [WW-1:0] w);
    logic [WW-1:0] l;
    logic [NSEG-1:0] f;
    for (int s = 0; s < NSEG; s++) begin
      int ones = 0;
      for (int b = 0; b < SEG_W; b++) ones += int'(w[s*SEG_W+b]);
      if (ones > SEG_W/2) begin
        l[s*SEG_W +: SEG_W] = w[s*SEG_W +: SEG_W];
        f[s] = 1'b0;
      end else begin
        l[s*SEG_W +: SEG_W] = ~w[s*SEG_W +: SEG_W];
        f[s] = 1'b1;
      end
    end
    return {f, l};
  endfunction

  // Driver: queue expectations, pulse start, return just before phase 7 is registered
  task automatic send_line(input logic [LW-1:0] l, input bit inject);
    for (int k = 0; k < PH; k++) begin
      logic [WW+NSEG-1:0] e;
      tx_item_t it;
      e = ref_enc(l[k*WW +: WW]);
      it.lines = e[WW-1:0];
      it.inv_n = e[WW +: NSEG];
      it.done  = (k == PH-1);
      exp_tx.push_back(it);
      if (loop_en) exp_rx.push_back(l[k*WW +: WW]);
    end
    line_data  = l;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int i = 0; i < PH-1; i++) begin
      if (inject && i == 2) begin
        line_start = 1'b1;          // R9: mid-line start must be ignored
        line_data  = ~l;
      end
      @(negedge clk);
      line_start = 1'b0;
    end
  endtask

  // Monitor: compare bus and receive outputs against the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (bus_tx_valid) begin
        if (exp_tx.size() == 0) begin
          check(1'b0, "R9 unexpected phase", {1'b0, bus_tx_inv_n, bus_tx_lines}, '0);
        end else begin
          tx_item_t e;
          e = exp_tx.pop_front();
          check(bus_tx_lines == e.lines && bus_tx_inv_n == e.inv_n,
                "R2 R3 R4 R5 R7 phase encoding",
                {line_done, bus_tx_inv_n, bus_tx_lines}, {e.done, e.inv_n, e.lines});
          check(line_done == e.done, "R8 done marker",
                {{(WW+4){1'b0}}, line_done}, {{(WW+4){1'b0}}, e.done});
          for (int s = 0; s < NSEG; s++) begin
            check($countones(~bus_tx_lines[s*SEG_W +: SEG_W]) <= SEG_W/2,
                  "R6 low-line limit",
                  (WW+5)'($countones(~bus_tx_lines[s*SEG_W +: SEG_W])), (WW+5)'(SEG_W/2));
          end
        end
      end else begin
        check(bus_tx_lines == '1 && bus_tx_inv_n == '1 && !line_done,
              "R1 idle bus", {line_done, bus_tx_inv_n, bus_tx_lines}, {1'b0, 4'hF, {WW{1'b1}}});
      end
      if (rx_word_valid) begin
        if (exp_rx.size() == 0) begin
          check(1'b0, "R10 unexpected rx word", (WW+5)'(rx_word), '0);
        end else begin
          logic [WW-1:0] r;
          r = exp_rx.pop_front();
          check(rx_word == r, "R10 R11 receive restore", (WW+5)'(rx_word), (WW+5)'(r));
        end
      end
    end
  end

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 watchdog: cycles=%0d expected below 100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] pat(input int i);
    case (i % 8)
      0: return 16'h0000;   // 0 ones
      1: return 16'hFFFF;   // 16 ones
      2: return 16'h00FF;   // exactly 8
      3: return 16'h01FF;   // 9
      4: return 16'h007F;   // 7
      5: return 16'hA5A5;   // exactly 8, scattered
      6: return 16'hFFFE;   // 15
      default: return 16'h8001;
    endcase
  endfunction

  initial begin
    logic [LW-1:0] la, lb;
    logic [WW-1:0] last_rx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(bus_tx_lines == '1 && bus_tx_inv_n == '1 && !bus_tx_valid && !line_done,
          "R1 reset tx", {line_done, bus_tx_inv_n, bus_tx_lines}, {1'b0, 4'hF, {WW{1'b1}}});
    check(!rx_word_valid && rx_word == '0, "R1 reset rx",
          {4'h0, rx_word_valid, rx_word}, '0);
    mon_on = 1'b1;

    // Threshold patterns rotated through every segment lane (R4 R5)
    for (int k = 0; k < PH; k++)
      for (int s = 0; s < NSEG; s++)
        la[k*WW + s*SEG_W +: SEG_W] = pat(k + s);
    send_line(la, 1'b0);
    repeat (4) @(negedge clk);

    // Mid-line start ignored (R9)
    for (int k = 0; k < PH*2; k++) lb[k*32 +: 32] = $urandom();
    send_line(lb, 1'b1);
    repeat (4) @(negedge clk);
    check(exp_tx.size() == 0, "R9 no extra phases", (WW+5)'(exp_tx.size()), '0);

    // Back-to-back lines (R9 R7)
    for (int n = 0; n < 4; n++) begin
      for (int k = 0; k < PH*2; k++) lb[k*32 +: 32] = $urandom();
      if (n == 2) lb[WW +: WW] = 64'hFF00_00FF_0F0F_3333;
      send_line(lb, 1'b0);
    end
    repeat (4) @(negedge clk);
    check(exp_tx.size() == 0 && exp_rx.size() == 0, "R7 R11 scoreboard drained",
          (WW+5)'(exp_tx.size() + exp_rx.size()), '0);

    // Direct receive (R10)
    loop_en = 1'b0;
    @(negedge clk);
    drv_lines = 64'h1234_FFFF_0000_ABCD; drv_inv_n = 4'b0101; drv_valid = 1'b1;
    exp_rx.push_back(64'h1234_0000_0000_5432);
    @(negedge clk);
    drv_lines = 64'h00FF_F0F0_1111_8000; drv_inv_n = 4'b1010;
    exp_rx.push_back(64'hFF00_F0F0_EEEE_8000);
    last_rx = 64'hFF00_F0F0_EEEE_8000;
    @(negedge clk);
    drv_valid = 1'b0;
    drv_lines = 64'hDEAD_BEEF_CAFE_F00D; drv_inv_n = 4'b0000;
    repeat (4) @(negedge clk);
    // R12: no update without valid
    check(rx_word == last_rx && !rx_word_valid, "R12 rx hold",
          {4'h0, rx_word_valid, rx_word}, {5'h0, last_rx});
    check(exp_rx.size() == 0, "R10 rx drained", (WW+5)'(exp_rx.size()), '0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule